// File: doc/BRIEF.md
# Prioritized Message Buffer Transmit Queue

This block holds several outgoing CAN messages and hands them, one at a time, to a separate transmit engine. Each message buffer has ten bytes: two header bytes carrying the 11-bit identifier, the remote-request flag and the data length code, followed by eight data bytes. A host fills the buffers through a byte-addressed register port. Writing the last data byte of a buffer queues that buffer for sending. No separate send command is needed.

When the engine is idle, the block offers the lowest-numbered queued buffer over a valid/ready handshake. While the engine sends it, the host may fill another buffer. Alternating between buffers in this way keeps the bus busy without gaps. The engine finishes each frame with one of two reports: success, or loss. A success releases the buffer and raises that buffer's completion flag, which the host can mask. A loss leaves the buffer queued, so it competes again for the next selection.

Top module: `msgbuf_txq`

## Requirements
- R1: Buffer b occupies addresses 10*b to 10*b+9 and reads back what was written. Offset 0 holds identifier bits 10..3. Offset 1 holds identifier bits 2..0 in bits 7..5, the remote flag in bit 4 and the length code in bits 3..0. Offset 2+k holds data byte k, which is presented on tx_data[8k+7:8k].
- R2: Writing offset 9 (data byte 7) of a buffer that is not queued sets that buffer's pending bit on the next clock. Writes to offsets 0 to 8 leave it clear. Pending bits are read at status address 32, bits 2..0.
- R3: While the engine is idle and any buffer is pending, tx_valid is high and tx_sel names the lowest-numbered pending buffer. The frame outputs show that buffer's contents.
- R4: Selection happens only while idle. After a handshake (tx_valid and tx_ready both high), tx_valid stays low until the engine reports, even if a higher-priority buffer becomes pending in the meantime.
- R5: A success report (tx_done with tx_ok high) during a transmission clears the active buffer's pending bit, sets its interrupt flag and returns the block to idle.
- R6: A loss report (tx_done with tx_ok low) returns the block to idle, leaves the buffer pending and sets no flag.
- R7: A host write to any byte of a pending buffer, whether queued or in transmission, leaves the byte unchanged and sets the sticky overwrite-error bit (status bit 7). Writing 1 to status bit 7 clears it.
- R8: Interrupt flags are at address 30, bits 2..0, and are cleared by writing 1. Mask bits are at address 31, bits 2..0. irq equals the OR over all buffers of flag AND mask.
- R9: After reset, all pending bits, flags, masks, the overwrite bit and irq are 0, and tx_valid is low.
- R10: A tx_done that arrives while no transmission is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 6 | Host write byte address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 6 | Host read byte address |
| rd_data | output | 8 | Host read data (combinational) |
| tx_valid | output | 1 | A frame is offered to the engine |
| tx_ready | input | 1 | Engine accepts the offered frame |
| tx_sel | output | 2 | Index of the offered or active buffer |
| tx_id | output | 11 | Frame identifier |
| tx_rtr | output | 1 | Remote request flag |
| tx_dlc | output | 4 | Data length code |
| tx_data | output | 64 | Data bytes, byte k at bits 8k+7..8k |
| tx_done | input | 1 | Engine finished the active frame |
| tx_ok | input | 1 | With tx_done: 1 = sent, 0 = lost |
| irq | output | 1 | Masked completion interrupt |

## Verification
A wrong pending bit shows up on the status read at once. It also shows up at the engine port on the next idle cycle, as a wrong or missing tx_valid or tx_sel. A wrong active index appears on the next report, because the completion flag then lands on the wrong buffer. A failed write lock shows up as a changed readback byte one clock after the blocked write. The flag and mask logic is visible on irq in the same cycle that the flag changes.

// File: rtl/msgbuf_txq.sv
module msgbuf_txq #(
  parameter int NBUF = 3,
  parameter int AW   = $clog2(NBUF * 10 + 3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [7:0]      rd_data,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [(NBUF>1 ? $clog2(NBUF) : 1)-1:0] tx_sel,
  output logic [10:0]     tx_id,
  output logic            tx_rtr,
  output logic [3:0]      tx_dlc,
  output logic [63:0]     tx_data,
  input  logic            tx_done,
  input  logic            tx_ok,
  output logic            irq
);
  localparam int BB       = 10;
  localparam int SELW     = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam int NBYTES   = NBUF * BB;
  localparam int A_IFL    = NBYTES;
  localparam int A_MSK    = NBYTES + 1;
  localparam int A_STA    = NBYTES + 2;
  localparam int LAST_OFF = BB - 1;

  logic [7:0]      mem [NBYTES];
  logic [NBUF-1:0] pend, iflag, imask;
  logic            ovr, busy;
  logic [SELW-1:0] act, sel, cur;

  logic [NBUF-1:0] w_hit;
  logic [3:0]      w_off;
  logic            w_in_buf, w_blocked, w_ok, w_last;
  logic [NBUF-1:0] pend_set, pend_clr, ifl_clr, act_oh;
  logic            take, fin;

  always_comb begin
    w_hit = '0;
    w_off = '0;
    for (int b = 0; b < NBUF; b++) begin
      if (int'(wr_addr) >= b * BB && int'(wr_addr) < (b + 1) * BB) begin
        w_hit[b] = 1'b1;
        w_off    = 4'(int'(wr_addr) - b * BB);
      end
    end
  end

  assign w_in_buf  = wr_en && (|w_hit);
  assign w_blocked = w_in_buf && (|(w_hit & pend));
  assign w_ok      = w_in_buf && !w_blocked;
  assign w_last    = w_ok && (w_off == 4'(LAST_OFF));

  always_comb begin
    sel = '0;
    for (int b = NBUF - 1; b >= 0; b--)
      if (pend[b]) sel = SELW'(b);
  end

  assign tx_valid = !busy && (|pend);
  assign cur      = busy ? act : sel;
  assign tx_sel   = cur;
  assign take     = tx_valid && tx_ready;
  assign fin      = busy && tx_done;
  assign act_oh   = NBUF'(1) << act;

  assign pend_set = w_last ? w_hit : '0;
  assign pend_clr = (fin && tx_ok) ? act_oh : '0;
  assign ifl_clr  = (wr_en && int'(wr_addr) == A_IFL) ? wr_data[NBUF-1:0] : '0;

  always_comb begin
    int base;
    base    = int'(cur) * BB;
    tx_id   = {mem[base], mem[base + 1][7:5]};
    tx_rtr  = mem[base + 1][4];
    tx_dlc  = mem[base + 1][3:0];
    for (int k = 0; k < 8; k++)
      tx_data[8*k +: 8] = mem[base + 2 + k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
      pend  <= '0;
      iflag <= '0;
      imask <= '0;
      ovr   <= 1'b0;
      busy  <= 1'b0;
      act   <= '0;
    end else begin
      if (w_ok) mem[int'(wr_addr)] <= wr_data;
      pend  <= (pend & ~pend_clr) | pend_set;
      iflag <= (iflag & ~ifl_clr) | pend_clr;
      if (wr_en && int'(wr_addr) == A_MSK) imask <= wr_data[NBUF-1:0];
      if (w_blocked) ovr <= 1'b1;
      else if (wr_en && int'(wr_addr) == A_STA && wr_data[7]) ovr <= 1'b0;
      if (take) begin
        busy <= 1'b1;
        act  <= sel;
      end else if (fin) begin
        busy <= 1'b0;
      end
    end
  end

  assign irq = |(iflag & imask);

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NBYTES)     rd_data = mem[int'(rd_addr)];
    else if (int'(rd_addr) == A_IFL) rd_data = 8'(iflag);
    else if (int'(rd_addr) == A_MSK) rd_data = 8'(imask);
    else if (int'(rd_addr) == A_STA) rd_data = {ovr, busy, 6'(pend)};
  end

  // R2
  last_byte_queues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_last |=> ((pend & $past(w_hit)) == $past(w_hit)));

  // R3
  sel_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> pend[tx_sel]);

  // R4
  no_reoffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !tx_valid);

  // R5
  ok_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && tx_ok) |=> (((pend & $past(act_oh)) == '0) && ((iflag & $past(act_oh)) != '0) && !busy));

  // R6
  loss_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !tx_ok) |=> (((pend & $past(act_oh)) != '0) && !busy));

  // R7
  overwrite_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_blocked |=> ovr);

  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take && tx_done && !w_last) |=> (pend == $past(pend)));
endmodule

// File: tb/msgbuf_txq_tb.sv
module msgbuf_txq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [1:0]  tx_sel;
  logic [10:0] tx_id;
  logic        tx_rtr;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic        tx_done = 1'b0;
  logic        tx_ok = 1'b0;
  logic        irq;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  msgbuf_txq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sel(tx_sel), .tx_id(tx_id), .tx_rtr(tx_rtr), .tx_dlc(tx_dlc), .tx_data(tx_data),
    .tx_done(tx_done), .tx_ok(tx_ok), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  b;
    logic [10:0] id;
    logic        rtr;
    logic [3:0]  dlc;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd0, 11'h7FF, 1'b0, 4'd8, 8'h10},
    '{2'd1, 11'h123, 1'b1, 4'd0, 8'hA5},
    '{2'd2, 11'h000, 1'b0, 4'd3, 8'hF0},
    '{2'd1, 11'h5AA, 1'b0, 4'd7, 8'h3C}
  };

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int k);
    return seed + 8'(k * 17);
  endfunction

  function automatic logic [63:0] dword(input logic [7:0] seed);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[8*k +: 8] = dbyte(seed, k);
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    rd_addr = 6'(a);
    #1;
    d = rd_data;
  endtask

  task automatic load(input int b, input logic [10:0] id, input logic rtr,
                      input logic [3:0] dlc, input logic [7:0] seed, input int upto);
    for (int o = 0; o <= upto; o++) begin
      if (o == 0)      wr(b * 10, id[10:3]);
      else if (o == 1) wr(b * 10 + 1, {id[2:0], rtr, dlc});
      else             wr(b * 10 + o, dbyte(seed, o - 2));
    end
  endtask

  task automatic handshake();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic report(input logic ok);
    @(negedge clk); tx_done = 1'b1; tx_ok = ok;
    @(negedge clk); tx_done = 1'b0; tx_ok = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 tx_valid", tx_valid, 0);
    check("R9 irq", irq, 0);
    rd(32, d); check("R9 status", d, 0);
    rd(30, d); check("R9 flags", d, 0);
    rd(31, d); check("R9 mask", d, 0);

    for (int v = 0; v < 4; v++) begin
      load(VECS[v].b, VECS[v].id, VECS[v].rtr, VECS[v].dlc, VECS[v].seed, 9);
      rd(32, d); check("R2 pending after byte 9", d, 8'(1) << VECS[v].b);
      rd(VECS[v].b * 10 + 1, d); check("R1 header readback", d, {VECS[v].id[2:0], VECS[v].rtr, VECS[v].dlc});
      check("R3 valid", tx_valid, 1);
      check("R3 sel", tx_sel, VECS[v].b);
      check("R1 id", tx_id, VECS[v].id);
      check("R1 rtr", tx_rtr, VECS[v].rtr);
      check("R1 dlc", tx_dlc, VECS[v].dlc);
      check("R1 data", tx_data, dword(VECS[v].seed));
      handshake();
      check("R4 valid low while busy", tx_valid, 0);
      report(1'b1);
      rd(32, d); check("R5 pending cleared", d, 0);
      rd(30, d); check("R5 flag set", d, 8'(1) << VECS[v].b);
      check("R8 irq masked off", irq, 0);
      wr(31, 8'(1) << VECS[v].b);
      check("R8 irq enabled", irq, 1);
      wr(30, 8'h07);
      rd(30, d); check("R8 flag w1c", d, 0);
      check("R8 irq after clear", irq, 0);
      wr(31, 8'h00);
    end

    // R2 partial fill does not queue
    load(2, 11'h321, 1'b0, 4'd8, 8'h55, 8);
    rd(32, d); check("R2 bytes 0..8 no queue", d, 0);
    check("R2 no valid", tx_valid, 0);
    wr(29, dbyte(8'h55, 7));
    rd(32, d); check("R2 byte 9 queues", d, 8'h04);

    // R3 priority, R4 no preemption, R6 loss
    load(1, 11'h111, 1'b0, 4'd2, 8'h01, 9);
    check("R3 lowest pending", tx_sel, 1);
    handshake();
    load(0, 11'h00F, 1'b1, 4'd1, 8'h02, 9);
    check("R4 no preempt valid", tx_valid, 0);
    check("R4 active sel", tx_sel, 1);
    report(1'b0);
    rd(32, d); check("R6 still pending", d, 8'h07);
    rd(30, d); check("R6 no flag", d, 0);
    check("R6 reoffer valid", tx_valid, 1);
    check("R3 new highest", tx_sel, 0);
    check("R1 id buf0", tx_id, 11'h00F);
    handshake(); report(1'b1);
    check("R3 next sel", tx_sel, 1);
    handshake(); report(1'b1);
    rd(30, d); check("R5 two flags", d, 8'h03);

    // R7 overwrite while queued and while sending
    check("R7 buf2 offered", tx_sel, 2);
    wr(20, 8'hAA);
    rd(20, d); check("R7 queued byte kept", d, 8'h64);
    rd(32, d); check("R7 ovr set", d, 8'h84);
    wr(32, 8'h80);
    rd(32, d); check("R7 ovr cleared", d, 8'h04);
    handshake();
    wr(23, 8'hBB);
    rd(23, d); check("R7 sending byte kept", d, dbyte(8'h55, 1));
    rd(32, d); check("R7 ovr set in tx", d, 8'hC4);
    report(1'b1);
    wr(32, 8'h80);

    // R8 partial masking and partial clear
    rd(30, d); check("R8 three flags", d, 8'h07);
    wr(31, 8'h04);
    check("R8 mask bit2 irq", irq, 1);
    wr(30, 8'h04);
    check("R8 bit2 cleared irq", irq, 0);
    rd(30, d); check("R8 others remain", d, 8'h03);
    wr(31, 8'h01);
    check("R8 mask bit0 irq", irq, 1);
    wr(30, 8'h03); wr(31, 8'h00);

    // R10 done while idle
    load(0, 11'h1AB, 1'b0, 4'd4, 8'h77, 9);
    report(1'b1);
    rd(32, d); check("R10 pending kept", d, 8'h01);
    rd(30, d); check("R10 no flag", d, 0);
    check("R10 still offered", tx_valid, 1);

    // R9 reset with work pending
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R9 valid after reset", tx_valid, 0);
    rd(32, d); check("R9 status after reset", d, 0);
    rd(0, d); check("R9 memory after reset", d, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule